// File: doc/BRIEF.md
# Four-Mode Recirculating Shift Register

This block is a 16-bit shift register steered by a 2-bit mode input. On every rising clock edge it carries out one of four operations. It can keep its contents, shift a bit in from the serial pin, rotate its contents out through the serial pin, or take a whole word from the parallel bus. The serial pin is bidirectional. At the block boundary it appears as three signals: an input bit, an output bit and an output enable, which a pad outside the block combines.

A read in serial mode does not destroy the word. The top bit goes out on the pin and the same bit re-enters at the bottom, so sixteen read clocks bring the original word back. A typical use loads a word in parallel, streams it out serially, and keeps it for later reads. The other use builds a word from serial input and reads it back the same way.

The operation applied at each edge comes from a small decoder. The decoder has five named operations: CLEAR, HOLD, WRITE, READ and LOAD.
- CLEAR is forced by reset and overrides the mode input.
- The other four operations follow the mode code directly.
- There are no sequencing transitions. Every edge applies the operation selected in the cycle before it: reset→CLEAR, 00→HOLD, 01→WRITE, 10→READ, 11→LOAD.

Top module: `srr_recirc_shift`

## Requirements
- R1: A synchronous active-high reset clears all 16 stored bits to zero at the rising edge. While reset is high, the pin output enable is low.
- R2: The mode code is sampled at the rising edge: 2'b00 hold, 2'b01 serial write, 2'b10 serial read, 2'b11 parallel load.
- R3: Parallel load replaces all 16 bits with the bus value in a single edge.
- R4: Serial write shifts the word one place toward bit 15. The pin input bit enters at bit 0, and the former bit 15 is discarded. A word written MSB first therefore ends up in its original bit order after 16 write edges.
- R5: Serial read shifts the word one place toward bit 15 and feeds the former bit 15 into bit 0. The sequence of bits presented on the pin is bit 15, bit 14, …, bit 0 of the word.
- R6: Sixteen serial-read edges restore the original word, even when holds are interleaved between them.
- R7: In hold mode the stored word does not change, whatever is applied on the pin input or the parallel bus, and the pin stays released.
- R8: The pin output enable is high only while the mode is serial read and reset is low. It is low in every other mode.
- R9: While the output enable is high, the pin output bit equals the current bit 15, before the edge that shifts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operation select (00 hold, 01 write, 10 read, 11 load) |
| par_in | input | 16 | Parallel load word |
| ser_in | input | 1 | Pin input side (serial write data) |
| ser_out | output | 1 | Pin output side (current bit 15) |
| ser_oe | output | 1 | Pin output enable, high in serial read only |

## Verification
A wrong stored bit is visible only through the pin. It shows up on the first read clock once it has rotated into bit 15, so at most sixteen read cycles after the fault. A broken feedback path shows up after the bit has made one complete pass. Its symptom is a second read-out that differs from the first. A wrong enable, or a mode decode that lets hold, write or load alter the word, appears in the same cycle on the enable output, or at the next full read-out as a corrupted word.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] MODE_HOLD  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_WRITE = 2'b01;
    localparam logic [MODE_W-1:0] MODE_READ  = 2'b10;
    localparam logic [MODE_W-1:0] MODE_LOAD  = 2'b11;

    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_HOLD  = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_LOAD  = 3'd4
    } op_e;

endpackage

// File: rtl/srr_mode_decode.sv
module srr_mode_decode
    import srr_pkg::*;
(
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output op_e               op
);

    always_comb begin
        if (rst) begin
            op = OP_CLEAR;
        end else begin
            unique case (mode)
                MODE_HOLD:  op = OP_HOLD;
                MODE_WRITE: op = OP_WRITE;
                MODE_READ:  op = OP_READ;
                MODE_LOAD:  op = OP_LOAD;
                default:    op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/srr_shift_core.sv
module srr_shift_core
    import srr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  op_e              op,
    input  logic [WIDTH-1:0] load_word,
    input  logic             shift_bit,
    output logic [WIDTH-1:0] word
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] word_d;

    // next-value selection, one branch per operation
    always_comb begin
        unique case (op)
            OP_CLEAR: word_d = '0;
            OP_HOLD:  word_d = word_q;
            OP_WRITE: word_d = {word_q[TOP-1:0], shift_bit};
            OP_READ:  word_d = {word_q[TOP-1:0], word_q[TOP]};
            OP_LOAD:  word_d = load_word;
            default:  word_d = word_q;
        endcase
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign word = word_q;

endmodule

// File: rtl/srr_pin_drive.sv
module srr_pin_drive
    import srr_pkg::*;
(
    input  op_e  op,
    input  logic top_bit,
    output logic pin_out,
    output logic pin_oe
);

    always_comb begin
        pin_out = top_bit;
        unique case (op)
            OP_READ: pin_oe = 1'b1;
            OP_CLEAR,
            OP_HOLD,
            OP_WRITE,
            OP_LOAD: pin_oe = 1'b0;
            default: pin_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/srr_recirc_shift.sv
module srr_recirc_shift
    import srr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [WIDTH-1:0]  par_in,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe
);

    op_e              op;
    logic [WIDTH-1:0] word_q;

    srr_mode_decode u_decode (
        .rst  (rst),
        .mode (mode),
        .op   (op)
    );

    srr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .op        (op),
        .load_word (par_in),
        .shift_bit (ser_in),
        .word      (word_q)
    );

    srr_pin_drive u_pin (
        .op      (op),
        .top_bit (word_q[WIDTH-1]),
        .pin_out (ser_out),
        .pin_oe  (ser_oe)
    );

endmodule

// File: rtl/srr_recirc_shift_chk.sv
module srr_recirc_shift_chk
    import srr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode,
    input logic [WIDTH-1:0]  par_in,
    input logic              ser_in,
    input logic              ser_out,
    input logic              ser_oe,
    input logic [WIDTH-1:0]  word_q
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (word_q == '0));

    a_r1_reset_releases: assert property (@(posedge clk)
        rst |-> !ser_oe);

    a_r3_load_word: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD) |=> (word_q == $past(par_in)));

    a_r4_write_shift: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=>
            (word_q == {$past(word_q[WIDTH-2:0]), $past(ser_in)}));

    a_r5_read_rotate: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_READ) |=>
            (word_q == {$past(word_q[WIDTH-2:0]), $past(word_q[WIDTH-1])}));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(word_q));

    a_r8_oe_read_only: assert property (@(posedge clk) disable iff (rst)
        ser_oe |-> (mode == MODE_READ));

    a_r8_oe_in_read: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_READ) |-> ser_oe);

    a_r9_pin_top_bit: assert property (@(posedge clk) disable iff (rst)
        ser_oe |-> (ser_out == word_q[WIDTH-1]));

endmodule

bind srr_recirc_shift srr_recirc_shift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .par_in  (par_in),
    .ser_in  (ser_in),
    .ser_out (ser_out),
    .ser_oe  (ser_oe),
    .word_q  (word_q)
);

// File: tb/tb_srr_recirc_shift.sv
module tb_srr_recirc_shift;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [15:0] par_in = '0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        ser_oe;

    int          checks = 0;
    int          fails = 0;
    logic        exp_q[$];
    logic [15:0] mdl = '0;
    logic        last_out;

    always #5 clk = ~clk;   // 100 MHz

    srr_recirc_shift dut (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .ser_out (ser_out),
        .ser_oe  (ser_oe)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, push expected pin bits, advance model
    task automatic step(input logic [1:0] m, input logic [15:0] p, input logic s);
        mode   = m;
        par_in = p;
        ser_in = s;
        #1;
        last_out = ser_out;
        if (!rst && m == 2'b10) exp_q.push_back(mdl[15]);
        if (rst)               mdl = '0;
        else if (m == 2'b01)   mdl = {mdl[14:0], s};
        else if (m == 2'b10)   mdl = {mdl[14:0], mdl[15]};
        else if (m == 2'b11)   mdl = p;
        @(posedge clk);
        #1;
    endtask

    task automatic read_word(input logic [15:0] exp, input string tag);
        logic [15:0] got = '0;
        for (int i = 0; i < 16; i++) begin
            step(2'b10, 16'hDEAD, 1'b1);
            if (i == 0) chk(last_out == exp[15], "R9", {31'd0, last_out}, {31'd0, exp[15]});
            got = {got[14:0], last_out};
        end
        chk(got == exp, tag, {16'd0, got}, {16'd0, exp});
    endtask

    // monitor: compare pin against scoreboard away from the active edge
    always @(negedge clk) begin
        if (!rst && mode == 2'b10) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", 32'd0, 32'd1);
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk(ser_out == e, "R5", {31'd0, ser_out}, {31'd0, e});
            end
        end
        chk(ser_oe === (!rst && mode == 2'b10), "R8",
            {31'd0, ser_oe}, {31'd0, (!rst && mode == 2'b10)});
    end

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears word and releases pin
        rst = 1'b1;
        repeat (3) step(2'b10, 16'hFFFF, 1'b1);
        chk(ser_oe == 1'b0, "R1", {31'd0, ser_oe}, 32'd0);
        rst = 1'b0;
        read_word(16'h0000, "R1");

        // R2 / R3: load code 11 takes full word in one edge
        step(2'b11, 16'hA5C3, 1'b0);
        read_word(16'hA5C3, "R3");
        // R6: second full read returns same word
        read_word(16'hA5C3, "R6");

        // R7: hold ignores pin and bus
        for (int i = 0; i < 5; i++) begin
            step(2'b00, 16'h1111 * i[15:0], i[0]);
            chk(ser_oe == 1'b0, "R7", {31'd0, ser_oe}, 32'd0);
        end
        read_word(16'hA5C3, "R7");

        // R4: write 0x1234 MSB first
        for (int i = 15; i >= 0; i--) begin
            logic [15:0] w = 16'h1234;
            step(2'b01, 16'hFFFF, w[i]);
        end
        read_word(16'h1234, "R4");

        // R4: partial write shifts toward bit 15
        step(2'b11, 16'hFFFF, 1'b0);
        step(2'b01, 16'h0000, 1'b0);
        step(2'b01, 16'h0000, 1'b1);
        step(2'b01, 16'h0000, 1'b0);
        step(2'b01, 16'h0000, 1'b0);
        read_word(16'hFFF4, "R4");

        // R2: code 11 then 00 keeps loaded word
        step(2'b11, 16'h3C96, 1'b1);
        step(2'b00, 16'h0000, 1'b0);
        read_word(16'h3C96, "R2");

        // R6: interrupted read (5, holds, 11) restores word
        step(2'b11, 16'h8001, 1'b0);
        for (int i = 0; i < 5; i++)  step(2'b10, 16'h0, 1'b0);
        for (int i = 0; i < 3; i++)  step(2'b00, 16'hFFFF, 1'b1);
        for (int i = 0; i < 11; i++) step(2'b10, 16'h0, 1'b0);
        read_word(16'h8001, "R6");

        // R1: reset during read clears stored word
        step(2'b11, 16'hBEEF, 1'b0);
        rst = 1'b1;
        step(2'b10, 16'h0, 1'b0);
        chk(ser_oe == 1'b0, "R1", {31'd0, ser_oe}, 32'd0);
        rst = 1'b0;
        read_word(16'h0000, "R1");

        chk(exp_q.size() == 0, "R5", exp_q.size(), 32'd0);
        step(2'b00, 16'h0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule